// File: doc/BRIEF.md
# Ethernet Statistics Counter Bank

This block keeps the statistics of an Ethernet MAC. The MAC raises a one-cycle strobe for each transmitted frame and for each received frame. With the strobe it gives the frame length and a flag vector that carries the frame class and the error flags. The bank has 37 counters. Each cycle, every counter adds the events that belong to it: a count of one, or a byte length. A transmit frame and a receive frame may arrive in the same cycle, and a counter that both of them touch adds both.

Software reaches the bank through a simple register port. A read returns its data one cycle after the request. A write to a counter address loads that counter. A carry status bit records each counter that wraps. A mask register enables those status bits onto one interrupt line. A control register holds two things: an option that clears a counter when it is read, and a bit that clears everything and then resets itself. A `fifo_mode` input freezes every counter except the six basic byte, packet, drop and FCS counters.

Top module: `rmon_stats_bank`

## Requirements
- R1: Counter indices are 0 tx bytes, 1 tx packets, 2 tx drops, 3 rx bytes, 4 rx packets, 5 rx FCS errors, 6..12 size bins, 13..21 rx flags 0..8 in flag order, 22 rx undersize, 23 rx oversize, 24 rx fragment, 25 rx jabber, 26 rx drops, 27 tx multicast, 28 tx broadcast, 29 tx pause, 30 tx deferred, 31 tx excess deferral, 32 tx single collision, 33 tx multiple collision, 34 tx late collision, 35 tx excess collision, 36 tx control. Byte counters add the frame length. Every other counter adds one per matching frame.
- R2: When a counter wraps past its all-ones value, carry status bit i is set, and that bit can be read at address 64 + i/32, bit i%32. Writing 1 to a status bit clears it. If a new carry arrives in the same cycle as that write, the new carry wins.
- R3: `irq` is the OR over all counters of the carry status bit ANDed with its mask bit. The mask bits live at address 72 + i/32, bit i%32. A masked carry never raises `irq`.
- R4: Clear-on-read is enabled by control bit 1 (address 80). With it on, a read of counter i returns the old value, and the counter restarts from whatever that counter adds in the same cycle.
- R5: Writing 1 to control bit 0 clears every counter and every carry status bit on the next clock edge. Bit 0 then reads back as 0 again.
- R6: While `fifo_mode` is 1, only counters 0..5 change on frame events. All other counters hold their value.
- R7: Size bins 6..12 cover these lengths in order: exactly 64, 65..127, 128..255, 256..511, 512..1023, 1024..1518, and 1519..1522. The last bin applies only to a frame with a standard VLAN tag. Transmit and receive frames both count in the bins.
- R8: A transmit frame is aborted when any of tx flags 5, 8, 9, 10, 11, 12 or 13 is set. An aborted frame adds nothing to counters 0, 1, 27..29, 36 or the size bins. Its error flags still count.
- R9: The rx oversize/jabber limit is 1522 only when rx flag 11 (standard VLAN tag) is set and rx flag 12 (custom tag) is clear. In every other case the limit is 1518, so a custom-tagged frame over 1518 bytes counts as oversize.
- R10: An rx frame shorter than 64 bytes counts as undersize, or as a fragment when rx flag 9 (FCS error) is set. An rx frame over the limit counts as oversize, or as jabber when rx flag 9 is set.
- R11: `reg_rvalid` and `reg_rdata` follow a read request by one cycle. Every counter, status bit, mask bit and control bit is 0 after reset. A write to address i < 37 loads counter i.
- R12: Tx flags: 0 multicast, 1 broadcast, 2 pause, 3 control, 4 deferred, 5 excess deferral, 6 single collision, 7 multiple collision, 8 late collision, 9 excess collision, 10 underrun, 11 bus error, 12 FIFO data error, 13 truncated, 14 drop, 15 standard VLAN tag. Rx flags 0..8 are multicast, broadcast, control, pause, unknown opcode, alignment, length error, code error, carrier sense. Rx flag 10 is drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | Restrict updates to counters 0..5 |
| tx_valid | input | 1 | Transmit frame strobe |
| tx_len | input | 16 | Transmit frame length in bytes |
| tx_flags | input | 16 | Transmit class and error flags |
| rx_valid | input | 1 | Receive frame strobe |
| rx_len | input | 16 | Receive frame length in bytes |
| rx_flags | input | 13 | Receive class and error flags |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after request |
| reg_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Masked carry interrupt |

## Verification
The bench drives a transmit frame and a receive frame of the same size in one cycle. A bin that took only one of the two increments would read 1 instead of 2. It sends an aborted frame and checks its bin and the packet count. A design that ignored the abort would move both. It checks standard-tagged and custom-tagged frames of 1520 bytes, where a shared length limit would misclassify one of them. It makes a counter wrap while its mask bit is clear. It also reads a counter with clear-on-read on in the same cycle as a frame that counts into it, where a wrong design loses that frame or returns the new value. Last, it checks that the global clear also empties the carry status and then drops back to 0.

// File: rtl/rmon_pkg.sv
package rmon_pkg;
  localparam int NUM_CTR = 37;
  localparam int LEN_W   = 16;
  localparam int INC_W   = LEN_W + 1;
  localparam int TXF_W   = 16;
  localparam int RXF_W   = 13;
  localparam int FIFO_CNT = 6;

  // counter indices
  localparam int C_TX_BYTES = 0;
  localparam int C_TX_PKTS  = 1;
  localparam int C_TX_DROP  = 2;
  localparam int C_RX_BYTES = 3;
  localparam int C_RX_PKTS  = 4;
  localparam int C_RX_FCS   = 5;
  localparam int C_BIN0     = 6;
  localparam int C_RX_FLAG0 = 13;
  localparam int C_RX_UNDER = 22;
  localparam int C_RX_OVER  = 23;
  localparam int C_RX_FRAG  = 24;
  localparam int C_RX_JAB   = 25;
  localparam int C_RX_DROP  = 26;
  localparam int C_TX_MCAST = 27;
  localparam int C_TX_BCAST = 28;
  localparam int C_TX_PAUSE = 29;
  localparam int C_TX_DEFER = 30;
  localparam int C_TX_XDEF  = 31;
  localparam int C_TX_SCOL  = 32;
  localparam int C_TX_MCOL  = 33;
  localparam int C_TX_LCOL  = 34;
  localparam int C_TX_XCOL  = 35;
  localparam int C_TX_CTRL  = 36;

  // transmit flag bits
  localparam int TXF_MCAST = 0;
  localparam int TXF_BCAST = 1;
  localparam int TXF_PAUSE = 2;
  localparam int TXF_CTRL  = 3;
  localparam int TXF_DEFER = 4;
  localparam int TXF_XDEF  = 5;
  localparam int TXF_SCOL  = 6;
  localparam int TXF_MCOL  = 7;
  localparam int TXF_LCOL  = 8;
  localparam int TXF_XCOL  = 9;
  localparam int TXF_UNDR  = 10;
  localparam int TXF_BERR  = 11;
  localparam int TXF_FERR  = 12;
  localparam int TXF_TRUNC = 13;
  localparam int TXF_DROP  = 14;
  localparam int TXF_VLAN  = 15;

  // receive flag bits
  localparam int RXF_FCS   = 9;
  localparam int RXF_DROP  = 10;
  localparam int RXF_VLAN  = 11;
  localparam int RXF_CVLAN = 12;

  localparam logic [2:0] BIN_NONE = 3'd7;

  function automatic logic tx_is_abort(input logic [TXF_W-1:0] f);
    return f[TXF_XDEF] | f[TXF_LCOL] | f[TXF_XCOL] | f[TXF_UNDR] |
           f[TXF_BERR] | f[TXF_FERR] | f[TXF_TRUNC];
  endfunction

  function automatic logic [2:0] size_bin(input int unsigned len, input logic vlan_ok,
                                          input int unsigned max_frm,
                                          input int unsigned vlan_max);
    if (len < 64)             return BIN_NONE;
    else if (len == 64)       return 3'd0;
    else if (len < 128)       return 3'd1;
    else if (len < 256)       return 3'd2;
    else if (len < 512)       return 3'd3;
    else if (len < 1024)      return 3'd4;
    else if (len <= max_frm)  return 3'd5;
    else if (vlan_ok && len <= vlan_max) return 3'd6;
    else                      return BIN_NONE;
  endfunction

  function automatic int unsigned len_limit(input logic std_tag, input logic custom_tag,
                                            input int unsigned max_frm,
                                            input int unsigned vlan_max);
    return (std_tag && !custom_tag) ? vlan_max : max_frm;
  endfunction
endpackage

// File: rtl/rmon_event_decode.sv
module rmon_event_decode
  import rmon_pkg::*;
#(
  parameter int unsigned MAX_FRM  = 1518,
  parameter int unsigned VLAN_MAX = 1522
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tx_valid,
  input  logic [LEN_W-1:0]                tx_len,
  input  logic [TXF_W-1:0]                tx_flags,
  input  logic                            rx_valid,
  input  logic [LEN_W-1:0]                rx_len,
  input  logic [RXF_W-1:0]                rx_flags,
  output logic [NUM_CTR-1:0][INC_W-1:0]   addend
);
  logic        tx_abort;
  logic [2:0]  tx_bin, rx_bin;
  logic        rx_short, rx_long;
  int unsigned rx_limit;

  assign tx_abort = tx_is_abort(tx_flags);
  assign tx_bin   = size_bin(32'(tx_len), tx_flags[TXF_VLAN], MAX_FRM, VLAN_MAX);
  assign rx_bin   = size_bin(32'(rx_len), rx_flags[RXF_VLAN] & ~rx_flags[RXF_CVLAN],
                             MAX_FRM, VLAN_MAX);
  assign rx_limit = len_limit(rx_flags[RXF_VLAN], rx_flags[RXF_CVLAN], MAX_FRM, VLAN_MAX);
  assign rx_short = 32'(rx_len) < 32'd64;
  assign rx_long  = 32'(rx_len) > rx_limit;

  always_comb begin
    addend = '0;
    if (tx_valid) begin
      if (!tx_abort) begin
        addend[C_TX_BYTES] = addend[C_TX_BYTES] + INC_W'(tx_len);
        addend[C_TX_PKTS]  = addend[C_TX_PKTS] + INC_W'(1);
        addend[C_TX_MCAST] = addend[C_TX_MCAST] + INC_W'(tx_flags[TXF_MCAST]);
        addend[C_TX_BCAST] = addend[C_TX_BCAST] + INC_W'(tx_flags[TXF_BCAST]);
        addend[C_TX_PAUSE] = addend[C_TX_PAUSE] + INC_W'(tx_flags[TXF_PAUSE]);
        addend[C_TX_CTRL]  = addend[C_TX_CTRL] + INC_W'(tx_flags[TXF_CTRL]);
        if (tx_bin != BIN_NONE)
          addend[C_BIN0 + int'(tx_bin)] = addend[C_BIN0 + int'(tx_bin)] + INC_W'(1);
      end
      addend[C_TX_DROP]  = addend[C_TX_DROP] + INC_W'(tx_flags[TXF_DROP]);
      addend[C_TX_DEFER] = addend[C_TX_DEFER] + INC_W'(tx_flags[TXF_DEFER]);
      addend[C_TX_XDEF]  = addend[C_TX_XDEF] + INC_W'(tx_flags[TXF_XDEF]);
      addend[C_TX_SCOL]  = addend[C_TX_SCOL] + INC_W'(tx_flags[TXF_SCOL]);
      addend[C_TX_MCOL]  = addend[C_TX_MCOL] + INC_W'(tx_flags[TXF_MCOL]);
      addend[C_TX_LCOL]  = addend[C_TX_LCOL] + INC_W'(tx_flags[TXF_LCOL]);
      addend[C_TX_XCOL]  = addend[C_TX_XCOL] + INC_W'(tx_flags[TXF_XCOL]);
    end
    if (rx_valid) begin
      addend[C_RX_BYTES] = addend[C_RX_BYTES] + INC_W'(rx_len);
      addend[C_RX_PKTS]  = addend[C_RX_PKTS] + INC_W'(1);
      addend[C_RX_FCS]   = addend[C_RX_FCS] + INC_W'(rx_flags[RXF_FCS]);
      addend[C_RX_DROP]  = addend[C_RX_DROP] + INC_W'(rx_flags[RXF_DROP]);
      for (int b = 0; b < 9; b++)
        addend[C_RX_FLAG0 + b] = addend[C_RX_FLAG0 + b] + INC_W'(rx_flags[b]);
      addend[C_RX_UNDER] = addend[C_RX_UNDER] + INC_W'(rx_short & ~rx_flags[RXF_FCS]);
      addend[C_RX_FRAG]  = addend[C_RX_FRAG] + INC_W'(rx_short & rx_flags[RXF_FCS]);
      addend[C_RX_OVER]  = addend[C_RX_OVER] + INC_W'(rx_long & ~rx_flags[RXF_FCS]);
      addend[C_RX_JAB]   = addend[C_RX_JAB] + INC_W'(rx_long & rx_flags[RXF_FCS]);
      if (rx_bin != BIN_NONE)
        addend[C_BIN0 + int'(rx_bin)] = addend[C_BIN0 + int'(rx_bin)] + INC_W'(1);
    end
  end

  AST_ABORT_NO_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_abort && !rx_valid) |->
      ({addend[6], addend[7], addend[8], addend[9], addend[10], addend[11], addend[12]} == '0)
      && addend[C_TX_PKTS] == '0); // R8
  AST_CUSTOM_TAG_OVERSIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_flags[RXF_CVLAN] && !rx_flags[RXF_FCS] && 32'(rx_len) > MAX_FRM) |->
      addend[C_RX_OVER] == INC_W'(1)); // R9
  AST_RUNT_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && 32'(rx_len) < 32'd64) |->
      (addend[C_RX_UNDER] + addend[C_RX_FRAG]) == INC_W'(1)); // R10
endmodule

// File: rtl/rmon_counter.sv
module rmon_counter #(
  parameter int CTR_W = 32,
  parameter int INC_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             load,
  input  logic [CTR_W-1:0] load_val,
  input  logic             rd_clr,
  input  logic             upd_en,
  input  logic [INC_W-1:0] addend,
  output logic [CTR_W-1:0] cnt_o,
  output logic             carry_o
);
  logic [INC_W-1:0] add_g;
  logic [CTR_W:0]   sum;

  assign add_g   = upd_en ? addend : '0;
  assign sum     = {1'b0, cnt_o} + (CTR_W+1)'(add_g);
  assign carry_o = !clr_all && !load && !rd_clr && sum[CTR_W];

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_o <= '0;
    else if (clr_all) cnt_o <= '0;
    else if (load)    cnt_o <= load_val;
    else if (rd_clr)  cnt_o <= CTR_W'(add_g);
    else              cnt_o <= sum[CTR_W-1:0];
  end

  AST_COR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !clr_all && !load) |=> cnt_o == $past(CTR_W'(add_g))); // R4
  AST_CARRY_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> cnt_o < $past(cnt_o)); // R2
endmodule

// File: rtl/rmon_carry_irq.sv
module rmon_carry_irq #(
  parameter int NUM_CTR = 37,
  parameter int DATA_W  = 32,
  parameter int NWORDS  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] carry_i,
  input  logic               clr_all,
  input  logic [NWORDS-1:0]  w1c_en,
  input  logic [NWORDS-1:0]  mask_we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_CTR-1:0] stat_o,
  output logic [NUM_CTR-1:0] mask_o,
  output logic               irq_o
);
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_bit
    localparam int W = i / DATA_W;
    localparam int B = i % DATA_W;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat_o[i] <= 1'b0;
        mask_o[i] <= 1'b0;
      end else begin
        if (clr_all)                      stat_o[i] <= 1'b0;
        else if (carry_i[i])              stat_o[i] <= 1'b1;
        else if (w1c_en[W] && wdata[B])   stat_o[i] <= 1'b0;
        if (mask_we[W]) mask_o[i] <= wdata[B];
      end
    end
    AST_CARRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_i[i] && !clr_all) |=> stat_o[i]); // R2
  end

  assign irq_o = |(stat_o & mask_o);

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == '0) |-> !irq_o); // R3
  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> stat_o == '0); // R5
endmodule

// File: rtl/rmon_stats_bank.sv
module rmon_stats_bank
  import rmon_pkg::*;
#(
  parameter int          CTR_W    = 32,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 7,
  parameter int unsigned MAX_FRM  = 1518,
  parameter int unsigned VLAN_MAX = 1522
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              tx_valid,
  input  logic [15:0]       tx_len,
  input  logic [15:0]       tx_flags,
  input  logic              rx_valid,
  input  logic [15:0]       rx_len,
  input  logic [12:0]       rx_flags,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              irq
);
  localparam int NWORDS    = (NUM_CTR + DATA_W - 1) / DATA_W;
  localparam int STAT_BASE = 64;
  localparam int MASK_BASE = 72;
  localparam int CTRL_ADDR = 80;

  logic [NUM_CTR-1:0][INC_W-1:0] addend;
  logic [CTR_W-1:0]   cnt [NUM_CTR];
  logic [NUM_CTR-1:0] carry, wr_ctr, rd_clr;
  logic [NUM_CTR-1:0] stat, mask;
  logic [NWORDS-1:0]  w1c_en, mask_we;
  logic               cor_en_q, clr_q;
  logic [NWORDS*DATA_W-1:0] stat_pad, mask_pad;
  logic [DATA_W-1:0]  rd_word;

  rmon_event_decode #(.MAX_FRM(MAX_FRM), .VLAN_MAX(VLAN_MAX)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_len(tx_len), .tx_flags(tx_flags),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_flags(rx_flags),
    .addend(addend)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign wr_ctr[i] = reg_wr && reg_addr == ADDR_W'(i);
    assign rd_clr[i] = reg_rd && cor_en_q && reg_addr == ADDR_W'(i);
    rmon_counter #(.CTR_W(CTR_W), .INC_W(INC_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_q),
      .load(wr_ctr[i]), .load_val(CTR_W'(reg_wdata)),
      .rd_clr(rd_clr[i]), .upd_en(!fifo_mode || i < FIFO_CNT),
      .addend(addend[i]), .cnt_o(cnt[i]), .carry_o(carry[i])
    );
    if (i >= FIFO_CNT) begin : g_fifo_chk
      AST_FIFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && !clr_q && !wr_ctr[i] && !rd_clr[i]) |=> $stable(cnt[i])); // R6
    end
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |=> cnt[i] == '0); // R5
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign w1c_en[w]  = reg_wr && reg_addr == ADDR_W'(STAT_BASE + w);
    assign mask_we[w] = reg_wr && reg_addr == ADDR_W'(MASK_BASE + w);
  end

  rmon_carry_irq #(.NUM_CTR(NUM_CTR), .DATA_W(DATA_W), .NWORDS(NWORDS)) u_irq (
    .clk(clk), .rst_n(rst_n), .carry_i(carry), .clr_all(clr_q),
    .w1c_en(w1c_en), .mask_we(mask_we), .wdata(reg_wdata),
    .stat_o(stat), .mask_o(mask), .irq_o(irq)
  );

  // control: bit 0 global clear (self-resetting), bit 1 clear-on-read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cor_en_q <= 1'b0;
      clr_q    <= 1'b0;
    end else if (reg_wr && reg_addr == ADDR_W'(CTRL_ADDR)) begin
      cor_en_q <= reg_wdata[1];
      clr_q    <= reg_wdata[0];
    end else begin
      clr_q    <= 1'b0;
    end
  end

  assign stat_pad = (NWORDS*DATA_W)'(stat);
  assign mask_pad = (NWORDS*DATA_W)'(mask);

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CTR; i++)
      if (reg_addr == ADDR_W'(i)) rd_word = DATA_W'(cnt[i]);
    for (int w = 0; w < NWORDS; w++) begin
      if (reg_addr == ADDR_W'(STAT_BASE + w)) rd_word = stat_pad[w*DATA_W +: DATA_W];
      if (reg_addr == ADDR_W'(MASK_BASE + w)) rd_word = mask_pad[w*DATA_W +: DATA_W];
    end
    if (reg_addr == ADDR_W'(CTRL_ADDR)) rd_word = DATA_W'({cor_en_q, clr_q});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_word;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid); // R11
  AST_CLR_SELF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q); // R5
endmodule

// File: tb/rmon_stats_bank_bench.sv
module rmon_stats_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode = 1'b0;
  logic        tx_valid = 1'b0, rx_valid = 1'b0;
  logic [15:0] tx_len = '0, tx_flags = '0, rx_len = '0;
  logic [12:0] rx_flags = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid, irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  rmon_stats_bank u_rmon_stats_bank (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .tx_valid(tx_valid), .tx_len(tx_len), .tx_flags(tx_flags),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_flags(rx_flags),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (reg_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected read data", reg_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(reg_rdata === e, t, reg_rdata, e);
      end
    end
  end

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic txf(input int len, input logic [15:0] fl);
    @(negedge clk);
    tx_valid = 1'b1; tx_len = 16'(len); tx_flags = fl;
    @(negedge clk);
    tx_valid = 1'b0; tx_flags = '0;
  endtask

  task automatic rxf(input int len, input logic [12:0] fl);
    @(negedge clk);
    rx_valid = 1'b1; rx_len = 16'(len); rx_flags = fl;
    @(negedge clk);
    rx_valid = 1'b0; rx_flags = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(irq == 1'b0, "R11 reset irq", {31'b0, irq}, 32'h0);
    rd(7'd0, 0, "R11 reset counter");
    rd(7'd64, 0, "R11 reset status");
    rd(7'd80, 0, "R11 reset control");

    txf(100, '0);                                  // R1 R7
    rd(7'd0, 100, "R1 tx bytes");
    rd(7'd1, 1, "R1 tx packets");
    rd(7'd7, 1, "R7 bin 65-127");

    rxf(64, 13'h001);                              // multicast
    rd(7'd3, 64, "R1 rx bytes");
    rd(7'd4, 1, "R1 rx packets");
    rd(7'd6, 1, "R7 bin 64");
    rd(7'd13, 1, "R12 rx multicast");

    @(negedge clk);                                // simultaneous tx+rx
    tx_valid = 1'b1; tx_len = 16'd200; rx_valid = 1'b1; rx_len = 16'd200;
    @(negedge clk);
    tx_valid = 1'b0; rx_valid = 1'b0;
    rd(7'd8, 2, "R7 bin 128-255 both directions");

    txf(300, 16'h0100);                            // late collision: aborted
    rd(7'd9, 0, "R8 aborted frame no bin");
    rd(7'd1, 2, "R8 aborted frame no packet");
    rd(7'd34, 1, "R8 late collision counted");

    rxf(1520, 13'h0800);                           // standard tag
    rd(7'd12, 1, "R7 bin tagged 1519-1522");
    rd(7'd23, 0, "R9 standard tag not oversize");
    rxf(1520, 13'h1000);                           // custom tag
    rd(7'd23, 1, "R9 custom tag oversize");
    rxf(1600, 13'h0200);
    rd(7'd25, 1, "R10 jabber");
    rd(7'd5, 1, "R1 rx fcs");
    rxf(40, '0);
    rd(7'd22, 1, "R10 undersize");
    rxf(40, 13'h0200);
    rd(7'd24, 1, "R10 fragment");

    fifo_mode = 1'b1;
    txf(100, 16'h0001);
    fifo_mode = 1'b0;
    rd(7'd0, 400, "R6 fifo mode tx bytes updates");
    rd(7'd27, 0, "R6 fifo mode multicast held");
    rd(7'd7, 1, "R6 fifo mode bin held");

    wr(7'd1, 32'hFFFF_FFFF);
    rd(7'd1, 32'hFFFF_FFFF, "R11 counter load");
    txf(64, '0);
    chk(irq == 1'b0, "R3 masked carry no irq", {31'b0, irq}, 32'h0);
    rd(7'd1, 0, "R2 counter wrapped");
    rd(7'd64, 2, "R2 carry status");
    wr(7'd72, 32'h2);
    chk(irq == 1'b1, "R3 unmasked carry irq", {31'b0, irq}, 32'h1);
    wr(7'd64, 32'h2);
    chk(irq == 1'b0, "R2 write-one clears status", {31'b0, irq}, 32'h0);
    rd(7'd64, 0, "R2 status cleared");

    wr(7'd80, 32'h2);                              // clear-on-read on
    rd(7'd0, 464, "R4 read returns value");
    rd(7'd0, 0, "R4 counter cleared by read");
    @(negedge clk);                                // read + event same cycle
    tx_valid = 1'b1; tx_len = 16'd70; reg_rd = 1'b1; reg_addr = 7'd1;
    exp_q.push_back(0); tag_q.push_back("R4 same-cycle read old value");
    @(negedge clk);
    tx_valid = 1'b0; reg_rd = 1'b0;
    rd(7'd1, 1, "R4 same-cycle event kept");
    rd(7'd1, 0, "R4 cleared again");
    rd(7'd0, 70, "R4 other counter unaffected");

    wr(7'd1, 32'hFFFF_FFFF);
    txf(64, '0);
    chk(irq == 1'b1, "R3 irq before clear", {31'b0, irq}, 32'h1);
    wr(7'd80, 32'h1);                              // global clear
    @(negedge clk);
    chk(irq == 1'b0, "R5 irq after clear", {31'b0, irq}, 32'h0);
    rd(7'd64, 0, "R5 status cleared");
    rd(7'd34, 0, "R5 counter cleared");
    rd(7'd0, 0, "R5 byte counter cleared");
    rd(7'd80, 0, "R5 clear bit self-reset");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11 reads outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule